// File: doc/BRIEF.md
# Five-Stage Pipelined Load-Store Datapath

This block is a small in-order processor datapath cut into five stages: fetch, decode, execute, memory access and writeback. A register bank sits between each pair of neighbouring stages, so up to five instructions are in flight at once. Each instruction spends exactly one cycle per stage. It has eight general registers and executes add, nand, load word, store word and a compare-equal branch. For the branch it produces a target and a taken decision but does not redirect fetch. The datapath has no hazard detection, forwarding, stall or flush logic. The program must therefore place every consumer at least three instructions after the instruction that produces its operand.

Instruction and data memories are internal word-addressed arrays of `2**AW` words. A preload port fills either one. The preload port is meant to be used while the core is held in reset. For observation, the block exposes the full register file, the writeback port and the branch outcome of the instruction in the memory stage. The reset input is asynchronous and active low. Its release passes through a two-flop synchroniser before the pipeline starts.

Top module: `pipe5_core`

## Requirements
- R1: While reset is held, and on release, every stage register holds a nop, all eight registers read 0, `wb_en` and `br_valid` are 0, and the program counter is 0, so the first instruction fetched is the word at address 0.
- R2: R-type words use bits [31:26]=0 with source fields rs=[23:21] and rt=[18:16] and destination rd=[13:11]. Function code 0x20 (bits [5:0]) writes rs+rt to rd, modulo 2^32.
- R3: An R-type word with function code 0x27 writes ~(rs & rt) to rd.
- R4: Opcode 0x23 (load) writes Mem[rs + sign-extended bits [15:0]] to register rt. The data memory index is the low AW bits of that sum, in words.
- R5: Opcode 0x2B (store) writes register rt to Mem[rs + sign-extended bits [15:0]] and writes no register.
- R6: For opcode 0x04 (branch), `br_valid` is 1 while the branch occupies the memory stage. `br_taken` is 1 exactly when rs equals rt, and `br_target` is PC+4 plus the sign-extended offset shifted left by 2. Fetch still advances by 4, so the words that follow the branch execute.
- R7: Only add, nand and load raise the register write. The all-zero word, other R-type function codes and undefined opcodes change no register and produce no writeback.
- R8: The instruction at address 0 reaches the writeback port in the 6th clock after reset is released (two synchroniser clocks plus four stage clocks). Back-to-back writers then appear on consecutive clocks.
- R9: A register write becomes visible to a read in the same cycle, so a consumer three instructions after its producer reads the new value.
- R10: Register 0 is an ordinary register: it can be loaded and then used as a base address.
- R11: While `ld_en` is 1, the word on `ld_data` is written at the next clock to instruction memory when `ld_dmem` is 0, or to data memory when `ld_dmem` is 1, at index `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| ld_addr | input | AW | Preload word index |
| ld_data | input | 32 | Preload word |
| wb_en | output | 1 | Writeback stage is writing a register this cycle |
| wb_idx | output | 3 | Register written by writeback |
| wb_data | output | 32 | Value written by writeback |
| br_valid | output | 1 | Memory-stage slot holds a branch |
| br_taken | output | 1 | That branch compares equal |
| br_target | output | 32 | That branch's computed target |
| dbg_regs | output | 256 | Register file, register i at bits [32*i+31:32*i] |

## Verification
The hardest cases to reach from the ports are those that depend on exact instruction spacing. One is a consumer placed exactly three slots after its producer, which is correct only through the same-cycle write bypass. Another is a load that must see a store issued a few slots earlier. The stimulus first seeds registers with loads from preloaded data words. It then places consumers at exactly the minimum legal distance, with nops as padding. It also uses a register loaded into r0 as a base, and a negative offset that wraps the address. Cycle timing is checked by logging every writeback event against a clock count taken from reset release.

// File: rtl/p5_pkg.sv
package p5_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 8;
  localparam int RIDX = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADD   = 6'h20;
  localparam logic [5:0] FN_NAND  = 6'h27;

  typedef enum logic [2:0] {K_NOP, K_ADD, K_NAND, K_LOAD, K_STORE, K_BEQ} kind_e;

  typedef struct packed {
    kind_e           kind;
    logic            reg_we;
    logic            mem_we;
    logic            mem_rd;
    logic            is_br;
    logic [RIDX-1:0] dst;
  } ctrl_t;

  typedef struct packed {
    logic [XLEN-1:0] inst;
    logic [XLEN-1:0] pc4;
  } fd_t;

  typedef struct packed {
    ctrl_t           c;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] a;
    logic [XLEN-1:0] b;
    logic [XLEN-1:0] pc4;
  } dx_t;

  typedef struct packed {
    ctrl_t           c;
    logic [XLEN-1:0] alu;
    logic [XLEN-1:0] sdata;
    logic            taken;
    logic [XLEN-1:0] target;
  } xm_t;

  typedef struct packed {
    ctrl_t           c;
    logic [XLEN-1:0] mdata;
    logic [XLEN-1:0] alu;
  } mw_t;
endpackage

// File: rtl/p5_ram.sv
module p5_ram #(
  parameter int AW = 6,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile #(
  parameter int NR = 8,
  parameter int W  = 32,
  parameter int NP = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [$clog2(NR)-1:0]       wa,
  input  logic [W-1:0]                wd,
  input  logic [NP-1:0][$clog2(NR)-1:0] ra,
  output logic [NP-1:0][W-1:0]        rd,
  output logic [NR*W-1:0]             dbg
);
  localparam int IW = $clog2(NR);
  logic [W-1:0] q     [NR];
  logic [W-1:0] q_nxt [NR];

  always_comb begin
    for (int i = 0; i < NR; i++) q_nxt[i] = q[i];
    if (we) q_nxt[wa] = wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) q[i] <= '0;
    end else begin
      for (int i = 0; i < NR; i++) q[i] <= q_nxt[i];
    end
  end

  for (genvar g = 0; g < NP; g++) begin : g_rd
    assign rd[g] = (we && (wa == ra[g])) ? wd : q[ra[g]];
  end

  for (genvar i = 0; i < NR; i++) begin : g_dbg
    assign dbg[i*W +: W] = q[i];
  end

  // R9: a write lands in the addressed register by the next cycle
  p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q[$past(wa)] == $past(wd)));

  logic [IW-1:0] unused_iw;
  assign unused_iw = '0;
endmodule

// File: rtl/p5_decode.sv
module p5_decode
  import p5_pkg::*;
(
  input  logic [XLEN-1:0] inst,
  output ctrl_t           c,
  output logic [XLEN-1:0] imm,
  output logic [RIDX-1:0] rs,
  output logic [RIDX-1:0] rt
);
  logic [5:0] op, fn;
  logic [RIDX-1:0] rd;

  assign op  = inst[31:26];
  assign fn  = inst[5:0];
  assign rs  = inst[21 +: RIDX];
  assign rt  = inst[16 +: RIDX];
  assign rd  = inst[11 +: RIDX];
  assign imm = {{(XLEN-16){inst[15]}}, inst[15:0]};

  always_comb begin
    c = '0;
    unique case (op)
      OP_RTYPE: begin
        if (fn == FN_ADD) begin
          c.kind = K_ADD; c.reg_we = 1'b1; c.dst = rd;
        end else if (fn == FN_NAND) begin
          c.kind = K_NAND; c.reg_we = 1'b1; c.dst = rd;
        end
      end
      OP_LOAD:  begin c.kind = K_LOAD; c.reg_we = 1'b1; c.mem_rd = 1'b1; c.dst = rt; end
      OP_STORE: begin c.kind = K_STORE; c.mem_we = 1'b1; end
      OP_BEQ:   begin c.kind = K_BEQ; c.is_br = 1'b1; end
      default:  c = '0;
    endcase
  end

  logic unused_fields;
  assign unused_fields = ^{inst[25:21+RIDX], inst[20:16+RIDX]};
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import p5_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_en,
  input  logic                 ld_dmem,
  input  logic [AW-1:0]        ld_addr,
  input  logic [31:0]          ld_data,
  output logic                 wb_en,
  output logic [2:0]           wb_idx,
  output logic [31:0]          wb_data,
  output logic                 br_valid,
  output logic                 br_taken,
  output logic [31:0]          br_target,
  output logic [NREG*XLEN-1:0] dbg_regs
);
  // reset release synchroniser
  logic rs1, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_core_n, rs1} <= 2'b00;
    else        {rst_core_n, rs1} <= {rs1, 1'b1};
  end

  logic [XLEN-1:0] pc, pc_nxt;
  fd_t fd, fd_nxt;
  dx_t dx, dx_nxt;
  xm_t xm, xm_nxt;
  mw_t mw, mw_nxt;

  logic [XLEN-1:0] imem_q, dmem_q, dec_imm;
  ctrl_t           dec_c;
  logic [RIDX-1:0] dec_rs, dec_rt;
  logic [1:0][RIDX-1:0] rf_ra;
  logic [1:0][XLEN-1:0] rf_rd;
  logic            dmem_we;
  logic [AW-1:0]   dmem_wa;
  logic [XLEN-1:0] dmem_wd, wb_val, alu;

  p5_ram #(.AW(AW), .W(XLEN)) u_imem (
    .clk(clk), .we(ld_en && !ld_dmem), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc[AW+1:2]), .rdata(imem_q));

  // preload port wins over a store in the same cycle
  assign dmem_we = ld_en ? ld_dmem : xm.c.mem_we;
  assign dmem_wa = ld_en ? ld_addr : xm.alu[AW-1:0];
  assign dmem_wd = ld_en ? ld_data : xm.sdata;

  p5_ram #(.AW(AW), .W(XLEN)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_wa), .wdata(dmem_wd),
    .raddr(xm.alu[AW-1:0]), .rdata(dmem_q));

  p5_decode u_dec (.inst(fd.inst), .c(dec_c), .imm(dec_imm), .rs(dec_rs), .rt(dec_rt));

  assign rf_ra[0] = dec_rs;
  assign rf_ra[1] = dec_rt;
  assign wb_val   = mw.c.mem_rd ? mw.mdata : mw.alu;

  p5_regfile #(.NR(NREG), .W(XLEN), .NP(2)) u_rf (
    .clk(clk), .rst_n(rst_core_n), .we(mw.c.reg_we), .wa(mw.c.dst), .wd(wb_val),
    .ra(rf_ra), .rd(rf_rd), .dbg(dbg_regs));

  // next-state logic for all stages
  always_comb begin
    pc_nxt     = pc + 32'd4;
    fd_nxt.inst = imem_q;
    fd_nxt.pc4  = pc + 32'd4;

    dx_nxt.c   = dec_c;
    dx_nxt.imm = dec_imm;
    dx_nxt.a   = rf_rd[0];
    dx_nxt.b   = rf_rd[1];
    dx_nxt.pc4 = fd.pc4;

    unique case (dx.c.kind)
      K_ADD:           alu = dx.a + dx.b;
      K_NAND:          alu = ~(dx.a & dx.b);
      K_LOAD, K_STORE: alu = dx.a + dx.imm;
      default:         alu = '0;
    endcase
    xm_nxt.c      = dx.c;
    xm_nxt.alu    = alu;
    xm_nxt.sdata  = dx.b;
    xm_nxt.taken  = dx.c.is_br && (dx.a == dx.b);
    xm_nxt.target = dx.pc4 + {dx.imm[XLEN-3:0], 2'b00};

    mw_nxt.c     = xm.c;
    mw_nxt.mdata = dmem_q;
    mw_nxt.alu   = xm.alu;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin pc <= '0; fd <= '0; end
    else begin pc <= pc_nxt; fd <= fd_nxt; end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) dx <= '0;
    else             dx <= dx_nxt;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) xm <= '0;
    else             xm <= xm_nxt;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) mw <= '0;
    else             mw <= mw_nxt;
  end

  assign wb_en     = mw.c.reg_we;
  assign wb_idx    = mw.c.dst;
  assign wb_data   = wb_val;
  assign br_valid  = xm.c.is_br;
  assign br_taken  = xm.taken;
  assign br_target = xm.target;

  p_pc_zero_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(rst_core_n) |-> (pc == '0));

  p_wb_kind_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    wb_en |-> (mw.c.kind == K_ADD || mw.c.kind == K_NAND || mw.c.kind == K_LOAD));

  p_wb_follows_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    xm.c.reg_we |=> wb_en);

  p_wb_quiet_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !xm.c.reg_we |=> !wb_en);

  p_br_align_r6: assert property (@(posedge clk) disable iff (!rst_core_n)
    br_valid |-> (br_target[1:0] == 2'b00));

  logic unused_mw;
  assign unused_mw = ^{mw.c.kind, mw.c.mem_we, mw.c.is_br};
endmodule

// File: tb/sim_pipe5_core.sv
module sim_pipe5_core;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          ld_en = 1'b0, ld_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic          wb_en, br_valid, br_taken;
  logic [2:0]    wb_idx;
  logic [31:0]   wb_data, br_target;
  logic [255:0]  dbg_regs;

  pipe5_core #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem), .ld_addr(ld_addr),
    .ld_data(ld_data), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target), .dbg_regs(dbg_regs));

  int checks = 0, fails = 0, pk = 0;
  bit done = 1'b0;

  // event logs, gathered from the ports
  int cyc = 0, wb_cnt = 0, wb_first = -1, wb_last = -1;
  logic [2:0]  wb_first_idx;
  logic [31:0] wb_first_data;
  int br_n = 0;
  logic        br_tk [4];
  logic [31:0] br_tg [4];
  int          br_cy [4];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      wb_cnt = 0; wb_first = -1; wb_last = -1; br_n = 0;
    end else begin
      if (wb_en) begin
        if (wb_first < 0) begin
          wb_first = cyc; wb_first_idx = wb_idx; wb_first_data = wb_data;
        end
        wb_last = cyc;
        wb_cnt++;
      end
      if (br_valid && br_n < 4) begin
        br_tk[br_n] = br_taken; br_tg[br_n] = br_target; br_cy[br_n] = cyc;
        br_n++;
      end
    end
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rget(int i);
    return dbg_regs[i*32 +: 32];
  endfunction

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  // R11: preload port, one word per clock
  task automatic ld(bit sel, int addr, logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_dmem = sel; ld_addr = AW'(addr); ld_data = d;
  endtask

  task automatic put(logic [31:0] w);
    ld(1'b0, pk, w);
    pk++;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int a = 0; a < (1 << AW); a++) ld(1'b0, a, 32'h0);
    pk = 0;
  endtask

  task automatic go(int n);
    @(negedge clk);
    ld_en = 1'b0;
    @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    hold_reset();
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk);
    chk("R1", "wb_en in reset", 32'(wb_en), 32'h0);
    chk("R1", "br_valid in reset", 32'(br_valid), 32'h0);
    for (int i = 0; i < 8; i++) chk("R1", $sformatf("r%0d in reset", i), rget(i), 32'h0);
    go(12);
    chk("R7", "writebacks from nop stream", wb_cnt, 0);
    chk("R7", "r1 after nops", rget(1), 32'h0);
  endtask

  task automatic t_arith();
    hold_reset();
    ld(1'b1, 0, 32'd5);
    ld(1'b1, 1, 32'd9);
    ld(1'b1, 2, 32'hF0F0_00FF);
    put(enc_i(6'h23, 1, 0, 16'd0));
    put(enc_i(6'h23, 2, 0, 16'd1));
    put(enc_i(6'h23, 3, 0, 16'd2));
    put(32'h0);
    put(enc_r(6'h20, 4, 1, 2));
    put(enc_r(6'h27, 5, 3, 2));
    put(32'h0);
    put(32'h0);
    put(enc_r(6'h20, 6, 4, 5));
    go(25);
    chk("R11", "r1 from preloaded data word", rget(1), 32'd5);
    chk("R4", "r3 load", rget(3), 32'hF0F0_00FF);
    chk("R2", "add r4", rget(4), 32'd14);
    chk("R9", "add r4 with operand 3 slots back", rget(4), 32'd5 + 32'd9);
    chk("R3", "nand r5", rget(5), ~(32'hF0F0_00FF & 32'd9));
    chk("R2", "add r6 wraps", rget(6), 32'd4);
    chk("R8", "first writeback clock", wb_first, 6);
    chk("R8", "first writeback index", 32'(wb_first_idx), 32'd1);
    chk("R1", "first writeback is word 0", wb_first_data, 32'd5);
    chk("R8", "last writeback clock", wb_last, 6 + 8);
    chk("R8", "writeback count", wb_cnt, 6);
  endtask

  task automatic t_mem();
    hold_reset();
    ld(1'b1, 4, 32'hAAAA_0004);
    ld(1'b1, 5, 32'h0000_1234);
    ld(1'b1, 7, 32'h0);
    ld(1'b1, 10, 32'd5);
    put(enc_i(6'h23, 1, 0, 16'd10));
    put(32'h0); put(32'h0); put(32'h0);
    put(enc_i(6'h23, 2, 1, 16'hFFFF));
    put(32'h0); put(32'h0); put(32'h0);
    put(enc_i(6'h2B, 2, 1, 16'd2));
    put(32'h0); put(32'h0);
    put(enc_i(6'h23, 3, 0, 16'd7));
    put(enc_i(6'h23, 0, 0, 16'd10));
    put(32'h0); put(32'h0);
    put(enc_i(6'h23, 4, 0, 16'd0));
    go(30);
    chk("R4", "negative offset load", rget(2), 32'hAAAA_0004);
    chk("R5", "stored word read back", rget(3), 32'hAAAA_0004);
    chk("R5", "store writes no register", wb_cnt, 5);
    chk("R10", "r0 loaded", rget(0), 32'd5);
    chk("R10", "r0 as base", rget(4), 32'h0000_1234);
  endtask

  task automatic t_branch();
    hold_reset();
    ld(1'b1, 10, 32'd5);
    ld(1'b1, 11, 32'd6);
    put(enc_i(6'h23, 1, 0, 16'd10));
    put(enc_i(6'h23, 2, 0, 16'd11));
    put(enc_i(6'h23, 3, 0, 16'd10));
    put(32'h0); put(32'h0);
    put(enc_i(6'h04, 3, 1, 16'd3));
    put(enc_i(6'h04, 2, 1, 16'hFFFE));
    put(enc_r(6'h20, 4, 1, 2));
    put(enc_i(6'h3F, 5, 1, 16'h0800));
    put(enc_r(6'h00, 6, 1, 2));
    go(25);
    chk("R6", "branch count", br_n, 2);
    chk("R6", "equal branch taken", 32'(br_tk[0]), 32'h1);
    chk("R6", "equal branch target", br_tg[0], 32'd36);
    chk("R6", "branch in memory stage clock", br_cy[0], 5 + 5);
    chk("R6", "unequal branch not taken", 32'(br_tk[1]), 32'h0);
    chk("R6", "backward target", br_tg[1], 32'd20);
    chk("R6", "word after branch still runs", rget(4), 32'd11);
    chk("R7", "undefined opcode writes nothing", rget(5), 32'h0);
    chk("R7", "unknown function writes nothing", rget(6), 32'h0);
    chk("R7", "writeback count", wb_cnt, 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arith();
    t_mem();
    t_branch();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule